// File: doc/BRIEF.md
# Write-Only Palette and Mode Control Registers

This block is the CPU-facing register file of a video and memory controller. It watches I/O write cycles on a 16-bit port address and claims a write only when the top address bit is 0 and the next bit is 1. The top two bits of the data byte then pick one of four functions:

- latch a pen index;
- store a colour into the pen that was latched;
- update a control register that sets the screen mode, enables or disables the two ROM windows and can pulse a clear to the raster interrupt counter;
- load a memory-bank configuration register.

Palette writes are indirect. One write chooses the pen and any number of later writes colour it. The block has no read path at all, so an I/O read to its port changes nothing and returns nothing. All results come out of registers and are meant to feed the pixel pipeline, the ROM decoder, the interrupt counter and the bank logic directly.

Top module: `vidctl_regs`

## Requirements
- R1: A write is claimed only when `io_wr` is 1, `addr[15]` is 0 and `addr[14]` is 1. The values of `addr[13:0]` do not affect selection. A write with any other combination of the two top bits changes no output.
- R2: `wdata[7:6]` selects the function of a claimed write: 00 pen select, 01 colour write, 10 mode/ROM/interrupt control, 11 bank configuration.
- R3: For a pen select, `wdata[4]`=0 latches pen `wdata[3:0]` (0 to 15). `wdata[4]`=1 latches the border entry, which is entry 16, whatever `wdata[3:0]` holds.
- R4: A colour write stores `wdata[4:0]` into the latched entry only. `palette[i*5 +: 5]` holds entry i, and entry 16 is the border. The latch persists, so repeated colour writes keep going to the same entry.
- R5: A control write sets `scr_mode` to `wdata[1:0]`. It sets `lower_rom_en` to the inverse of `wdata[2]` and `upper_rom_en` to the inverse of `wdata[3]`.
- R6: `irq_cnt_clr` is 1 for exactly the cycle after a claimed control write with `wdata[4]`=1, and 0 otherwise.
- R7: A bank write loads `wdata[5:0]` into `bank_cfg` and leaves the palette, the pen latch and the control outputs unchanged.
- R8: `io_rd` has no effect on any state or output, whatever the address.
- R9: While `rst` is high at a clock edge, the pen latch, all 17 colours, `scr_mode` and `bank_cfg` clear to 0, both ROM enables go to 1, and `irq_cnt_clr` is 0.
- R10: Every output updates at the clock edge that samples the write and is stable until the next write that affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, sampled each edge |
| io_rd | input | 1 | I/O read strobe (ignored) |
| addr | input | 16 | I/O port address |
| wdata | input | 8 | Write data byte |
| palette | output | 85 | 17 colour entries of 5 bits; entry 16 is the border |
| scr_mode | output | 2 | Screen mode |
| lower_rom_en | output | 1 | Lower ROM window enabled |
| upper_rom_en | output | 1 | Upper ROM window enabled |
| irq_cnt_clr | output | 1 | One-cycle interrupt counter clear |
| bank_cfg | output | 6 | Memory bank configuration |

## Verification
Every result of a write is due one cycle after it: the edge that samples the write also updates the register behind the output. The colour of a pen select followed by a colour write therefore shows two edges after the select. The interrupt clear is high only in the cycle after its control write. The bench drives inputs on the falling edge and lets its reference model advance on the rising edge. It compares all outputs with the model on the next falling edge, so each check lands exactly on the cycle in which the result is due and again in every later cycle while the result must hold.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;
  typedef enum logic [1:0] {
    FN_PEN  = 2'b00,
    FN_INK  = 2'b01,
    FN_CTRL = 2'b10,
    FN_BANK = 2'b11
  } fn_e;
endpackage

// File: rtl/vidctl_decode.sv
module vidctl_decode
  import vidctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              pen_we,
  output logic              ink_we,
  output logic              ctrl_we,
  output logic              bank_we
);
  logic chip_sel;
  fn_e  fn;
  logic unused_addr;

  assign unused_addr = ^addr[ADDR_W-3:0];
  assign chip_sel    = io_wr & ~addr[ADDR_W-1] & addr[ADDR_W-2];
  assign fn          = fn_e'(wdata[DATA_W-1 -: 2]);

  always_comb begin
    pen_we  = 1'b0;
    ink_we  = 1'b0;
    ctrl_we = 1'b0;
    bank_we = 1'b0;
    if (chip_sel) begin
      unique case (fn)
        FN_PEN:  pen_we  = 1'b1;
        FN_INK:  ink_we  = 1'b1;
        FN_CTRL: ctrl_we = 1'b1;
        FN_BANK: bank_we = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/vidctl_palette.sv
module vidctl_palette #(
  parameter int NUM_PENS = 16,
  parameter int COLOR_W  = 5,
  parameter int DATA_W   = 8,
  localparam int NUM_REGS  = NUM_PENS + 1,
  localparam int PEN_IDX_W = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        pen_we,
  input  logic                        ink_we,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_REGS*COLOR_W-1:0] palette
);
  logic [PEN_IDX_W-1:0] pen_q;
  logic [PEN_IDX_W-1:0] pen_d;
  logic [COLOR_W-1:0]   col_q [NUM_REGS];
  logic                 unused_data;

  assign unused_data = ^wdata[DATA_W-1:PEN_IDX_W];

  // Top bit of the index field picks the border entry outright
  always_comb begin
    if (wdata[PEN_IDX_W-1]) pen_d = PEN_IDX_W'(NUM_PENS);
    else                    pen_d = {1'b0, wdata[PEN_IDX_W-2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)         pen_q <= '0;
    else if (pen_we) pen_q <= pen_d;
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst)                                          col_q[i] <= '0;
        else if (ink_we && pen_q == PEN_IDX_W'(i))        col_q[i] <= wdata[COLOR_W-1:0];
      end
      assign palette[i*COLOR_W +: COLOR_W] = col_q[i];

      // R4: an entry only moves after a colour write aimed at it
      p_entry_guard_r4: assert property (@(posedge clk) disable iff (rst)
        !($past(ink_we) && $past(pen_q) == PEN_IDX_W'(i)) |-> $stable(palette[i*COLOR_W +: COLOR_W]));
    end
  endgenerate

  // R3: latched index never points past the border entry
  p_pen_range_r3: assert property (@(posedge clk) disable iff (rst)
    pen_q <= PEN_IDX_W'(NUM_PENS));
  // R4: latch only moves on a pen select
  p_pen_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !pen_we |=> $stable(pen_q));
endmodule

// File: rtl/vidctl_ctrl.sv
module vidctl_ctrl #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [MODE_W-1:0] scr_mode,
  output logic              lower_rom_en,
  output logic              upper_rom_en,
  output logic              irq_cnt_clr
);
  localparam int LROM_BIT = MODE_W;
  localparam int UROM_BIT = MODE_W + 1;
  localparam int IRQ_BIT  = MODE_W + 2;

  logic unused_data;
  assign unused_data = ^wdata[DATA_W-1:IRQ_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scr_mode     <= '0;
      lower_rom_en <= 1'b1;
      upper_rom_en <= 1'b1;
      irq_cnt_clr  <= 1'b0;
    end else begin
      irq_cnt_clr <= ctrl_we & wdata[IRQ_BIT];
      if (ctrl_we) begin
        scr_mode     <= wdata[MODE_W-1:0];
        lower_rom_en <= ~wdata[LROM_BIT];
        upper_rom_en <= ~wdata[UROM_BIT];
      end
    end
  end

  // R6: clear pulse only follows a control write requesting it
  p_irq_src_r6: assert property (@(posedge clk) disable iff (rst)
    irq_cnt_clr |-> $past(ctrl_we));
  // R5: control outputs hold without a control write
  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> ($stable(scr_mode) && $stable(lower_rom_en) && $stable(upper_rom_en)));
endmodule

// File: rtl/vidctl_bank.sv
module vidctl_bank #(
  parameter int DATA_W = 8,
  parameter int MAP_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [MAP_W-1:0]  bank_cfg
);
  logic unused_data;
  assign unused_data = ^wdata[DATA_W-1:MAP_W];

  always_ff @(posedge clk) begin
    if (rst)          bank_cfg <= '0;
    else if (bank_we) bank_cfg <= wdata[MAP_W-1:0];
  end

  // R7: bank register holds unless a bank write is claimed
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bank_we |=> $stable(bank_cfg));
endmodule

// File: rtl/vidctl_regs.sv
module vidctl_regs #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_PENS = 16,
  parameter int COLOR_W  = 5,
  parameter int MODE_W   = 2,
  parameter int MAP_W    = 6,
  localparam int NUM_REGS = NUM_PENS + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        io_wr,
  input  logic                        io_rd,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_REGS*COLOR_W-1:0] palette,
  output logic [MODE_W-1:0]           scr_mode,
  output logic                        lower_rom_en,
  output logic                        upper_rom_en,
  output logic                        irq_cnt_clr,
  output logic [MAP_W-1:0]            bank_cfg
);
  logic pen_we, ink_we, ctrl_we, bank_we;
  logic unused_rd;

  // R8: reads have no path into the block
  assign unused_rd = io_rd;

  vidctl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .io_wr(io_wr), .addr(addr), .wdata(wdata),
    .pen_we(pen_we), .ink_we(ink_we), .ctrl_we(ctrl_we), .bank_we(bank_we)
  );

  vidctl_palette #(.NUM_PENS(NUM_PENS), .COLOR_W(COLOR_W), .DATA_W(DATA_W)) u_palette (
    .clk(clk), .rst(rst), .pen_we(pen_we), .ink_we(ink_we),
    .wdata(wdata), .palette(palette)
  );

  vidctl_ctrl #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .wdata(wdata),
    .scr_mode(scr_mode), .lower_rom_en(lower_rom_en),
    .upper_rom_en(upper_rom_en), .irq_cnt_clr(irq_cnt_clr)
  );

  vidctl_bank #(.DATA_W(DATA_W), .MAP_W(MAP_W)) u_bank (
    .clk(clk), .rst(rst), .bank_we(bank_we), .wdata(wdata), .bank_cfg(bank_cfg)
  );

  // R1: a write with an unselected address leaves every register alone
  p_unsel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && !addr[ADDR_W-1] && addr[ADDR_W-2]) |=>
      ($stable(palette) && $stable(bank_cfg) && $stable(scr_mode) && !irq_cnt_clr));
  // R2: at most one function fires per write
  p_one_fn_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pen_we, ink_we, ctrl_we, bank_we}));
endmodule

// File: tb/vidctl_regs_bench.sv
`timescale 1ns/1ps
module vidctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic [84:0] palette;
  logic [1:0]  scr_mode;
  logic        lower_rom_en, upper_rom_en, irq_cnt_clr;
  logic [5:0]  bank_cfg;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_pal [17];
  int m_pen, m_mode, m_lrom, m_urom, m_irq, m_bank;

  always #10 clk = ~clk;

  vidctl_regs u_vidctl_regs (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .addr(addr), .wdata(wdata),
    .palette(palette), .scr_mode(scr_mode), .lower_rom_en(lower_rom_en),
    .upper_rom_en(upper_rom_en), .irq_cnt_clr(irq_cnt_clr), .bank_cfg(bank_cfg)
  );

  // Reference model advances on the same edge as the design (R10)
  always @(posedge clk) begin
    if (rst) begin // R9
      for (int i = 0; i < 17; i++) m_pal[i] = 0;
      m_pen = 0; m_mode = 0; m_lrom = 1; m_urom = 1; m_irq = 0; m_bank = 0;
    end else begin
      m_irq = 0;
      if (io_wr && addr[15] == 1'b0 && addr[14] == 1'b1) begin // R1
        case (wdata[7:6]) // R2
          2'b00: m_pen = wdata[4] ? 16 : int'(wdata[3:0]);     // R3
          2'b01: m_pal[m_pen] = int'(wdata[4:0]);              // R4
          2'b10: begin                                          // R5, R6
            m_mode = int'(wdata[1:0]);
            m_lrom = wdata[2] ? 0 : 1;
            m_urom = wdata[3] ? 0 : 1;
            m_irq  = wdata[4] ? 1 : 0;
          end
          default: m_bank = int'(wdata[5:0]);                   // R7
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every falling edge once reset has been applied
  always @(negedge clk) begin
    if (!done && $time > 15) begin
      logic [84:0] exp_pal;
      for (int i = 0; i < 17; i++) exp_pal[i*5 +: 5] = 5'(m_pal[i]);
      check(palette == exp_pal, "R4 palette", longint'(palette[63:0]), longint'(exp_pal[63:0]));
      check(scr_mode == 2'(m_mode), "R5 scr_mode", scr_mode, m_mode);
      check(lower_rom_en == 1'(m_lrom) && upper_rom_en == 1'(m_urom), "R5 rom_en",
            {lower_rom_en, upper_rom_en}, {1'(m_lrom), 1'(m_urom)});
      check(irq_cnt_clr == 1'(m_irq), "R6 irq_cnt_clr", irq_cnt_clr, m_irq);
      check(bank_cfg == 6'(m_bank), "R7 bank_cfg", bank_cfg, m_bank);
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    #1; io_wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    #1; io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    #1; io_rd = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    #1; io_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state, checked directly
    check(palette == '0 && bank_cfg == 6'd0 && scr_mode == 2'd0, "R9 reset clear",
          longint'(palette[63:0]), 0);
    check(lower_rom_en && upper_rom_en && !irq_cnt_clr, "R9 reset roms",
          {lower_rom_en, upper_rom_en, irq_cnt_clr}, 3'b110);
    #1 rst = 1'b0;

    // R3/R4: colour each pen through the canonical port
    for (int p = 0; p < 16; p++) begin
      io_write(16'h7F00, 8'(p));
      io_write(16'h7FFF, 8'h40 | 8'((p * 7 + 3) % 32));
    end
    // R3: border select, low bits ignored
    io_write(16'h7F00, 8'h1F);
    io_write(16'h7F00, 8'h5A);
    check(palette[84:80] == 5'h1A, "R3 border entry", palette[84:80], 5'h1A);
    check(palette[79:75] == 5'((15 * 7 + 3) % 32), "R3 pen15 untouched", palette[79:75], (15*7+3)%32);
    // R4: latch persists
    io_write(16'h7F00, 8'h10);
    io_write(16'h7F00, 8'h45);
    check(palette[84:80] == 5'h05, "R4 second write same entry", palette[84:80], 5'h05);

    // R1: other address bits do not matter; wrong top bits do nothing
    io_write(16'h4000, 8'hC9);
    check(bank_cfg == 6'h09, "R1 low bits zero still selects", bank_cfg, 6'h09);
    io_write(16'hBF00, 8'hD5);
    io_write(16'h3F00, 8'hD5);
    io_write(16'hFFFF, 8'hD5);
    check(bank_cfg == 6'h09, "R1 unselected address ignored", bank_cfg, 6'h09);

    // R5/R6: control writes
    io_write(16'h7F00, 8'h8E);
    check(scr_mode == 2'd2 && !lower_rom_en && !upper_rom_en, "R5 mode and roms",
          {scr_mode, lower_rom_en, upper_rom_en}, 4'b1000);
    @(negedge clk); #1; io_wr = 1'b1; addr = 16'h7F00; wdata = 8'h91;
    @(negedge clk);
    check(irq_cnt_clr == 1'b1, "R6 pulse after write", irq_cnt_clr, 1);
    #1 io_wr = 1'b0;
    @(negedge clk);
    check(irq_cnt_clr == 1'b0, "R6 pulse one cycle", irq_cnt_clr, 0);

    // R7: bank write leaves palette and control alone
    io_write(16'h7F00, 8'hFF);
    check(bank_cfg == 6'h3F && scr_mode == 2'd1, "R7 bank only", bank_cfg, 6'h3F);

    // R8: reads to the port change nothing
    io_read(16'h7F00, 8'h80);
    io_read(16'h7F00, 8'hC0);
    check(bank_cfg == 6'h3F && scr_mode == 2'd1 && lower_rom_en, "R8 read ignored",
          bank_cfg, 6'h3F);

    // Mixed traffic, model compared every cycle (R2, R10)
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      #1;
      io_wr = 1'($urandom % 2);
      io_rd = 1'($urandom % 2);
      addr  = 16'($urandom);
      if ($urandom % 2 == 1) addr[15:14] = 2'b01;
      wdata = 8'($urandom);
    end
    @(negedge clk); #1 io_wr = 1'b0; io_rd = 1'b0;

    // R9: reset mid-run
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(palette == '0 && lower_rom_en && upper_rom_en && bank_cfg == 6'd0, "R9 reset again",
          longint'(palette[63:0]), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule